// File: doc/BRIEF.md
# Hysteretic PLL Lock Detector

This block decides whether a phase-locked loop is in lock. It watches a stream of signed phase-error samples. Each sample arrives with a one-cycle strobe. A single up/down counter moves up while the error magnitude stays within a programmable threshold. The locked flag rises when the counter reaches a programmable lock count.

Large errors walk the counter back down, but only as far as a separate, lower floor. Reaching that floor clears the counter to zero, drops the lock flag and emits a one-cycle lost-lock pulse. Because the floor sits below the lock count, a locked loop can absorb a short burst of bad samples without losing lock. The difference between the lock count and the floor sets how large that burst may be.

The three settings are the threshold, the lock count and the floor. They are captured only while the init pulse is high. Init also clears the counter and both outputs, so a controller issues init with the new settings whenever it restarts acquisition.

Top module: `lock_det_hyst`

## Requirements
- R1: A sample is in range when the magnitude of `smp_err`, read as two's complement, is less than or equal to the captured threshold, read as unsigned. The most negative error value has magnitude 2^(ERR_W-1).
- R2: An in-range sample increments the counter when the counter is below the captured lock count. Otherwise the counter holds, so it saturates at the lock count.
- R3: When an in-range sample leaves the counter equal to the lock count, `locked` is high from the clock edge that takes that sample.
- R4: An out-of-range sample decrements the counter when the counter is above the captured floor. While the result stays above the floor, `locked` keeps its value.
- R5: When an out-of-range sample leaves the counter equal to the floor, the counter becomes 0 and `locked` goes low. `lost_lock` is high for exactly the one cycle after the edge that takes that sample. This happens whether or not the detector was locked.
- R6: An out-of-range sample that finds the counter below the floor changes nothing and produces no pulse.
- R7: In cycles where `smp_vld` is low and `init` is low, the counter and `locked` keep their values, and `lost_lock` is low.
- R8: `init` clears the counter, `locked` and `lost_lock`, and captures `cfg_thresh`, `cfg_lock_cnt` and `cfg_unlock_cnt`. `init` takes priority over a sample in the same cycle. While `init` is low, the configuration inputs have no effect.
- R9: Synchronous active-high `rst` clears the counter, the captured settings and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Restart pulse; clears state and captures the settings |
| smp_vld | input | 1 | Strobe marking a valid error sample |
| smp_err | input | ERR_W | Signed phase-error sample |
| cfg_thresh | input | ERR_W | Unsigned in-range magnitude threshold |
| cfg_lock_cnt | input | CNT_W | Counter value at which lock is declared |
| cfg_unlock_cnt | input | CNT_W | Floor at which lock is lost; must be below the lock count |
| locked | output | 1 | Registered lock flag |
| lost_lock | output | 1 | One-cycle pulse when the counter hits the floor |

## Verification
The bench builds the block with ERR_W = 8 and CNT_W = 6.

The 8-bit error width brings the most negative sample (-128) within reach. Against thresholds of 127 and 128, that sample shows the inclusive magnitude comparison at its edge.

The small counter allows a lock count of 8 with a floor of 5, so a handful of samples covers several full lock and unlock cycles. That includes saturation at the lock count, the walk down to the floor, and a lost-lock pulse raised from an unlocked state when the counter meets the floor while still climbing. A zero floor shows a pulse on the very first out-of-range sample.

// File: rtl/ld_pkg.sv
package ld_pkg;
  typedef enum logic [1:0] {
    SMP_NONE = 2'd0,
    SMP_IN   = 2'd1,
    SMP_OUT  = 2'd2
  } smp_kind_t;
endpackage

// File: rtl/ld_classify.sv
module ld_classify
  import ld_pkg::*;
#(
  parameter int ERR_W = 24
) (
  input  logic             vld,
  input  logic [ERR_W-1:0] err,
  input  logic [ERR_W-1:0] thr,
  output smp_kind_t        kind
);
  logic [ERR_W-1:0] mag;

  // magnitude as unsigned; the most negative value maps to 2^(ERR_W-1)
  always_comb begin
    mag = err[ERR_W-1] ? (~err + ERR_W'(1)) : err;
    if (!vld)           kind = SMP_NONE;
    else if (mag <= thr) kind = SMP_IN;
    else                 kind = SMP_OUT;
  end
endmodule

// File: rtl/ld_counter.sv
module ld_counter
  import ld_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  smp_kind_t        kind,
  input  logic [CNT_W-1:0] lock_n,
  input  logic [CNT_W-1:0] floor_n,
  output logic             set_lk,
  output logic             drop_lk
);
  logic [CNT_W-1:0] cnt, nxt;

  always_comb begin
    nxt     = cnt;
    set_lk  = 1'b0;
    drop_lk = 1'b0;
    case (kind)
      SMP_IN: begin
        if (cnt < lock_n) nxt = cnt + CNT_W'(1);
        if (nxt == lock_n) set_lk = 1'b1;
      end
      SMP_OUT: begin
        if (cnt > floor_n) nxt = cnt - CNT_W'(1);
        if (nxt == floor_n) begin
          nxt     = '0;
          drop_lk = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || init) cnt <= '0;
    else             cnt <= nxt;
  end

  // R2
  cnt_cap_chk: assert property (@(posedge clk) disable iff (rst)
    !init |-> cnt <= lock_n);
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && kind == SMP_NONE) |=> $stable(cnt));
  // R8
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> cnt == '0);
endmodule

// File: rtl/ld_flag.sv
module ld_flag (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic set_lk,
  input  logic drop_lk,
  output logic locked,
  output logic lost
);
  always_ff @(posedge clk) begin
    if (rst || init) begin
      locked <= 1'b0;
      lost   <= 1'b0;
    end else begin
      lost <= drop_lk;
      if (drop_lk)     locked <= 1'b0;
      else if (set_lk) locked <= 1'b1;
    end
  end

  // R5
  lost_unlocked_chk: assert property (@(posedge clk) disable iff (rst)
    lost |-> !locked);
endmodule

// File: rtl/lock_det_hyst.sv
module lock_det_hyst
  import ld_pkg::*;
#(
  parameter int ERR_W = 24,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             smp_vld,
  input  logic [ERR_W-1:0] smp_err,
  input  logic [ERR_W-1:0] cfg_thresh,
  input  logic [CNT_W-1:0] cfg_lock_cnt,
  input  logic [CNT_W-1:0] cfg_unlock_cnt,
  output logic             locked,
  output logic             lost_lock
);
  logic [ERR_W-1:0] thr_q;
  logic [CNT_W-1:0] lock_q, floor_q;
  smp_kind_t        kind;
  logic             set_lk, drop_lk;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q   <= '0;
      lock_q  <= '0;
      floor_q <= '0;
    end else if (init) begin
      thr_q   <= cfg_thresh;
      lock_q  <= cfg_lock_cnt;
      floor_q <= cfg_unlock_cnt;
    end
  end

  ld_classify #(.ERR_W(ERR_W)) u_cls (
    .vld (smp_vld && !init),
    .err (smp_err),
    .thr (thr_q),
    .kind(kind)
  );

  ld_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .init   (init),
    .kind   (kind),
    .lock_n (lock_q),
    .floor_n(floor_q),
    .set_lk (set_lk),
    .drop_lk(drop_lk)
  );

  ld_flag u_flag (
    .clk    (clk),
    .rst    (rst),
    .init   (init),
    .set_lk (set_lk),
    .drop_lk(drop_lk),
    .locked (locked),
    .lost   (lost_lock)
  );

  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !init |=> ($stable(thr_q) && $stable(lock_q) && $stable(floor_q)));
  // R3
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(smp_vld && !init));
  // R5
  lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
    lost_lock |-> $past(smp_vld && !init));
endmodule

// File: tb/sim_lock_det_hyst.sv
module sim_lock_det_hyst;
  localparam int EW = 8;
  localparam int CW = 6;

  logic          clk = 1'b0, rst = 1'b1, init = 1'b0, vld = 1'b0;
  logic [EW-1:0] err = '0, thr = '0;
  logic [CW-1:0] lkn = '0, dln = '0;
  logic          locked, lost;

  always #10 clk = ~clk;

  lock_det_hyst #(.ERR_W(EW), .CNT_W(CW)) u0 (
    .clk(clk), .rst(rst), .init(init), .smp_vld(vld), .smp_err(err),
    .cfg_thresh(thr), .cfg_lock_cnt(lkn), .cfg_unlock_cnt(dln),
    .locked(locked), .lost_lock(lost)
  );

  int checks = 0, errors = 0;
  bit q_lk[$];
  bit q_lo[$];
  string q_tag[$];
  bit was_ev = 1'b0, last_lk = 1'b0, mon_on = 1'b0;
  int m_cnt = 0, m_lk = 0, m_thr = 0, m_lock = 0, m_dl = 0;

  always @(posedge clk) was_ev <= vld | init;

  task automatic chk(bit got, bit exp, string tag, string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // monitor: pops one expectation per sample or init; idle cycles must hold
  always @(negedge clk) if (mon_on) begin
    if (was_ev) begin
      bit elk, elo;
      string t;
      elk = q_lk.pop_front();
      elo = q_lo.pop_front();
      t   = q_tag.pop_front();
      chk(locked, elk, t, "locked");
      chk(lost, elo, t, "lost_lock");
      last_lk = elk;
    end else begin
      chk(locked, last_lk, "R7", "idle locked");
      chk(lost, 1'b0, "R7", "idle lost_lock");
    end
  end

  task automatic send(int e, string tag);
    int mag;
    bit lo;
    @(negedge clk);
    init = 1'b0;
    vld  = 1'b1;
    err  = EW'(e);
    mag  = (e < 0) ? -e : e;
    lo   = 1'b0;
    if (mag <= m_thr) begin
      if (m_cnt < m_lock) m_cnt++;
      if (m_cnt == m_lock) m_lk = 1;
    end else begin
      if (m_cnt > m_dl) m_cnt--;
      if (m_cnt == m_dl) begin
        m_cnt = 0;
        m_lk  = 0;
        lo    = 1'b1;
      end
    end
    q_lk.push_back(m_lk != 0);
    q_lo.push_back(lo);
    q_tag.push_back(tag);
  endtask

  task automatic gap(int n);
    @(negedge clk);
    vld = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic do_init(int t, int l, int d, string tag);
    @(negedge clk);
    vld  = 1'b0;
    init = 1'b1;
    thr  = EW'(t);
    lkn  = CW'(l);
    dln  = CW'(d);
    m_thr = t; m_lock = l; m_dl = d; m_cnt = 0; m_lk = 0;
    q_lk.push_back(1'b0);
    q_lo.push_back(1'b0);
    q_tag.push_back(tag);
    @(negedge clk);
    init = 1'b0;
    // settings changed while init is low must be ignored (R8)
    thr = '0;
    lkn = CW'(1);
    dln = '0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(locked, 1'b0, "R9", "reset locked");
    chk(lost, 1'b0, "R9", "reset lost_lock");
    rst = 1'b0;
    @(negedge clk);
    mon_on = 1'b1;

    do_init(10, 8, 5, "R8");
    send(10, "R1"); send(-10, "R1");
    send(0, "R2");  send(3, "R2"); send(-7, "R2"); send(9, "R2"); send(1, "R2");
    send(-2, "R3");
    send(4, "R2");
    gap(3);
    send(11, "R4"); send(-11, "R4");
    send(50, "R5");
    gap(2);
    send(-60, "R6"); send(60, "R6"); send(-11, "R6");
    gap(2);
    for (int i = 0; i < 5; i++) send(0, "R2");
    send(20, "R5");
    gap(1);
    for (int i = 0; i < 8; i++) send(i - 4, "R3");
    gap(2);
    do_init(10, 8, 5, "R8");
    send(5, "R8");
    gap(2);

    do_init(127, 2, 0, "R8");
    send(-128, "R1");
    send(-127, "R1"); send(127, "R3");
    gap(2);
    do_init(128, 2, 0, "R8");
    send(-128, "R1"); send(-128, "R3");
    gap(3);
    mon_on = 1'b0;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end
endmodule